// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Unit

This unit watches a wide vector of general-purpose pins. The pins fall into port-sized groups, and each group produces one interrupt request. Within a group, a per-pin mask chooses which pins matter. A rising or a falling level on any chosen pin sets a sticky flag for that group. The request line for the group is that flag gated by an enable bit. Software clears a flag by writing a one to it, and then reads the port itself to find which pin moved. The unit looks only at the pin level, so it also reacts when the chip drives the pin as an output. This lets software raise an interrupt on purpose.

With the default parameters there are 39 pins in five groups. Groups 0 to 3 each cover eight pins. Group 4 covers the last seven. In normal operation the pins pass through a two-flop synchronizer and are compared with the sample from the cycle before. When the chip is about to sleep, it raises a sleep input. The unit then freezes a snapshot of the pin levels and compares the raw pins with it through a purely combinational path. Any masked-in difference drives a wake output, even while the clock is stopped.

Top module: `pinchg_irq_unit`

## Requirements
- R1: A level change in either direction on a pin whose mask bit is set sets that pin's group flag. The flag is set at the third rising clock edge after the pin changes.
- R2: Group g covers pins 8g to 8g+7 for g = 0..3, and group 4 covers pins 32 to 38. A change only sets the flag of the group that owns the pin.
- R3: The mask of group g is written and read at bus address g, and data bit i selects pin 8g+i. A change on a pin whose mask bit is clear has no effect. Bit 7 of the group 4 mask has no pin and always reads 0.
- R4: The enable register sits at address 5, with bit g for group g. grp_req_o[g] is high exactly when flag g and enable g are both set.
- R5: The flags read at address 6, with bit g for group g. Writing a one to a bit clears that flag, and writing a zero leaves it unchanged.
- R6: If a masked change would set a flag in the same cycle that a write clears it, the flag stays set.
- R7: Setting a mask bit for a pin that changed earlier, while its mask bit was clear, does not set the flag.
- R8: While sleep_i is high, wake_o is high with no clock edge needed whenever any masked pin differs from the level it had when sleep_i rose. wake_o is low while sleep_i is low.
- R9: After reset, all masks, enables and flags read 0, and grp_req_o and wake_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register bus and the change detection |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | 39 | Raw pin levels, asynchronous |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address: 0 to 4 are masks, 5 is enable, 6 is flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| sleep_i | input | 1 | High while the chip sleeps; freezes the wake snapshot |
| grp_req_o | output | 5 | Interrupt request for each group |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
The assertions assume that each pin holds its level long enough for the synchronizer to capture it. They also assume that sleep_i rises only after the pins have been stable for at least two clock cycles, so that the frozen snapshot matches the real pin levels. The random stimulus always changes the pins and then waits four cycles before it touches the bus. Sleep is entered only after long stable stretches. The directed cases place the clear write in the exact cycle of the collision, and they toggle pins while the clock is stopped.

// File: rtl/pcu_pkg.sv
// Package for the pin-change unit: helpers that size the pin groups.
// Assumes that the pins are packed low to high and that every group except the last one is full.
package pcu_pkg;

    // Width of group g when npins pins are split into groups of gw pins
    function automatic int grp_width(int g, int npins, int gw);
        int rest;
        rest = npins - g * gw;
        return (rest < gw) ? rest : gw;
    endfunction

endpackage

// File: rtl/pcu_sync.sv
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes that each bit is independent; a bit may be skewed by one cycle against another.
module pcu_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two register stages bring the raw pins into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/pcu_group.sv
// One pin group: holds the mask register, the previous sample, the sticky flag and the gated request.
// Assumes pin_s_i is already synchronized. The previous sample tracks every pin, whatever the mask,
// so that a mask edit never looks like a change.
module pcu_group #(
    parameter int W      = 8,
    parameter int FULL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pin_s_i,
    input  logic              mask_we_i,
    input  logic [W-1:0]      mask_wdata_i,
    input  logic              clr_i,
    input  logic              en_i,
    output logic [FULL_W-1:0] mask_o,
    output logic              flag_o,
    output logic              req_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] mask_q;
    logic         flag_q;
    logic         hit;

    // Previous sample follows every pin each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_s_i;
    end

    // Mask register, written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    // Any masked pin differs from its last sample
    assign hit = |((pin_s_i ^ prev_q) & mask_q);

    // Sticky flag: a new change wins over a write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (hit)   flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    // Mask is zero-extended to the bus width for read-back
    always_comb begin
        mask_o         = '0;
        mask_o[W-1:0]  = mask_q;
    end

    assign flag_o = flag_q;
    assign req_o  = flag_q & en_i;

    assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);
    assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_i) |=> flag_q);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !flag_q);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !hit) |=> $stable(flag_q));
endmodule

// File: rtl/pcu_wake.sv
// Wake path: freezes a snapshot of the synchronized pins while sleep_i is high. It then compares the raw pins
// with that snapshot through logic that needs no clock.
// Assumes that sleep_i rises only after the pins have been stable for at least two cycles.
module pcu_wake #(
    parameter int NPINS = 39
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_raw_i,
    input  logic [NPINS-1:0] pin_s_i,
    input  logic [NPINS-1:0] mask_i,
    input  logic             sleep_i,
    output logic             wake_o
);
    logic [NPINS-1:0] snap_q;

    // Snapshot tracks the pins while awake and holds once sleep is requested
    always_ff @(posedge clk) begin
        if (!rst_n)        snap_q <= '0;
        else if (!sleep_i) snap_q <= pin_s_i;
    end

    // Clock-free comparison of the raw pins against the frozen levels
    assign wake_o = sleep_i & (|((pin_raw_i ^ snap_q) & mask_i));

    assert_snap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && $past(sleep_i)) |-> $stable(snap_q));
endmodule

// File: rtl/pinchg_irq_unit.sv
// Top of the grouped pin-change interrupt unit. It decodes the register bus, holds the group enables
// and builds one pcu_group per port group.
// Assumes that GRP_W is at least the number of groups, so that the enable and flag registers fit one bus word.
module pinchg_irq_unit #(
    parameter int NUM_PINS = 39,
    parameter int GRP_W    = 8,
    localparam int NUM_GRP = (NUM_PINS + GRP_W - 1) / GRP_W,
    localparam int ADDR_W  = $clog2(NUM_GRP + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [GRP_W-1:0]    bus_wdata,
    output logic [GRP_W-1:0]    bus_rdata,
    input  logic                sleep_i,
    output logic [NUM_GRP-1:0]  grp_req_o,
    output logic                wake_o
);
    localparam logic [ADDR_W-1:0] ENA_ADDR = ADDR_W'(NUM_GRP);
    localparam logic [ADDR_W-1:0] FLG_ADDR = ADDR_W'(NUM_GRP + 1);

    logic [NUM_PINS-1:0] pin_s;
    logic [NUM_PINS-1:0] mask_all;
    logic [GRP_W-1:0]    mask_arr [NUM_GRP];
    logic [NUM_GRP-1:0]  flag_v;
    logic [NUM_GRP-1:0]  en_q;
    logic [NUM_GRP-1:0]  clr_v;

    pcu_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    // Group enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                           en_q <= '0;
        else if (bus_we && bus_addr == ENA_ADDR) en_q <= bus_wdata[NUM_GRP-1:0];
    end

    // Write-one-to-clear strobes for the flags
    assign clr_v = (bus_we && bus_addr == FLG_ADDR) ? bus_wdata[NUM_GRP-1:0] : '0;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int LO = g * GRP_W;
        localparam int W  = pcu_pkg::grp_width(g, NUM_PINS, GRP_W);

        pcu_group #(.W(W), .FULL_W(GRP_W)) u_grp (
            .clk          (clk),
            .rst_n        (rst_n),
            .pin_s_i      (pin_s[LO +: W]),
            .mask_we_i    (bus_we && bus_addr == ADDR_W'(g)),
            .mask_wdata_i (bus_wdata[W-1:0]),
            .clr_i        (clr_v[g]),
            .en_i         (en_q[g]),
            .mask_o       (mask_arr[g]),
            .flag_o       (flag_v[g]),
            .req_o        (grp_req_o[g])
        );

        assign mask_all[LO +: W] = mask_arr[g][W-1:0];

        assert_req_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[g] |-> !grp_req_o[g]);
    end

    pcu_wake #(.NPINS(NUM_PINS)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_raw_i (pin_i),
        .pin_s_i   (pin_s),
        .mask_i    (mask_all),
        .sleep_i   (sleep_i),
        .wake_o    (wake_o)
    );

    // Read multiplexer for masks, enables and flags
    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (bus_addr == ADDR_W'(g)) bus_rdata = mask_arr[g];
        end
        if (bus_addr == ENA_ADDR) bus_rdata[NUM_GRP-1:0] = en_q;
        if (bus_addr == FLG_ADDR) bus_rdata[NUM_GRP-1:0] = flag_v;
    end

    assert_wake_asleep_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> sleep_i);
endmodule

// File: tb/test_pinchg_irq_unit.sv
module test_pinchg_irq_unit;
    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        rst_n;
    logic [38:0] pin_i;
    logic        bus_we;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        sleep_i;
    logic [4:0]  grp_req_o;
    logic        wake_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] mask_m [5];
    logic [4:0] en_m;
    logic [4:0] flag_m;

    pinchg_irq_unit i_pinchg_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_i(sleep_i),
        .grp_req_o(grp_req_o), .wake_o(wake_o)
    );

    always #2 if (clk_run) clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Masked change per group between two pin vectors
    function automatic logic [4:0] exp_hits(logic [38:0] a, logic [38:0] b);
        logic [63:0] d;
        d = 64'(a ^ b);
        for (int g = 0; g < 5; g++) exp_hits[g] = |(d[g*8 +: 8] & mask_m[g]);
    endfunction

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a < 3'd5) mask_m[a] = (a == 3'd4) ? (d & 8'h7f) : d;
        else if (a == 3'd5) en_m = d[4:0];
        else if (a == 3'd6) flag_m = flag_m & ~d[4:0];
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic check_flags(string req);
        logic [7:0] d;
        rd(3'd6, d);
        check(req, d, {3'b0, flag_m});
        check(req, grp_req_o, flag_m & en_m);
    endtask

    task automatic set_pins(logic [38:0] p);
        flag_m = flag_m | exp_hits(pin_i, p);
        pin_i = p;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        rst_n = 1'b0; pin_i = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; sleep_i = 1'b0;
        for (int g = 0; g < 5; g++) mask_m[g] = '0;
        en_m = '0; flag_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        for (int a = 0; a < 7; a++) begin rd(3'(a), d); check("R9", d, 0); end
        check("R9", grp_req_o, 0);
        check("R9", wake_o, 0);

        // R7: change with mask clear, then unmask: no event
        set_pins(39'h55_0000_00ff);
        wr(3'd0, 8'hff); wr(3'd4, 8'hff); wr(3'd5, 8'h1f);
        repeat (3) @(negedge clk);
        check_flags("R7");
        rd(3'd4, d); check("R3", d, 8'h7f);

        // R1 R2: single pin rising then falling in group 4 only
        set_pins(pin_i ^ (39'h1 << 38));
        check_flags("R2");
        wr(3'd6, 8'h10); check_flags("R5");
        set_pins(pin_i ^ (39'h1 << 38));
        check_flags("R1");

        // R5: writing zeros leaves flags
        wr(3'd6, 8'h00); check_flags("R5");
        wr(3'd6, 8'hff); check_flags("R5");

        // R6: clear lands in the same cycle as the new change
        pin_i = pin_i ^ 39'h1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 8'h01;
        @(negedge clk);
        bus_we = 1'b0;
        rd(3'd6, d); check("R6", d[0], 1'b1);
        flag_m = 5'h01;
        wr(3'd6, 8'h1f); check_flags("R6");

        // R3 R4: random masks, enables, pins and clears
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 3) == 0) wr(3'($urandom_range(0, 4)), 8'($urandom));
            if ($urandom_range(0, 3) == 0) wr(3'd5, 8'($urandom));
            set_pins(pin_i ^ (39'({$urandom, $urandom}) & 39'({$urandom, $urandom}) & 39'({$urandom, $urandom})));
            check_flags("R3");
            if ($urandom_range(0, 1) == 0) begin
                wr(3'd6, 8'($urandom)); check_flags("R4");
            end
        end

        // R8: wake with the clock stopped
        wr(3'd0, 8'h00); for (int g = 1; g < 5; g++) wr(3'(g), 8'hff);
        repeat (4) @(negedge clk);
        check("R8", wake_o, 0);
        sleep_i = 1'b1;
        @(negedge clk); @(negedge clk);
        clk_run = 1'b0;
        #10;
        check("R8", wake_o, 0);
        pin_i[35] = ~pin_i[35]; #1; check("R8", wake_o, 1);
        pin_i[35] = ~pin_i[35]; #1; check("R8", wake_o, 0);
        pin_i[3] = ~pin_i[3];   #1; check("R8", wake_o, 0);
        pin_i[12] = ~pin_i[12]; #1; check("R8", wake_o, 1);
        sleep_i = 1'b0; #1; check("R8", wake_o, 0);
        pin_i[12] = ~pin_i[12]; pin_i[3] = ~pin_i[3];
        clk_run = 1'b1;
        repeat (4) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule